// File: doc/BRIEF.md
# Byte-Writable Non-Volatile Memory Write Sequencer

This block models the control side of a 2048-byte non-volatile memory that sits on an SRAM-style bus. All inputs are sampled on the system clock. A byte write is framed by the overlap of the active-low select and write strobes. The address is taken when that overlap begins and the data byte when it ends. A timed internal cycle then erases the target byte to all ones and programs the latched value. While the cycle runs, the block raises a busy flag and answers reads of the target byte with a status byte instead of stored data, so software can poll for completion.

A second command wipes every byte back to the erased value. It is entered by holding select and write strobe low while a qualifier input reports a high-voltage level on the output-enable pin. Write protection comes from the output enable: a strobe given while output enable is low is discarded. Any strobe that arrives while a cycle is running is ignored.

Top module: `nvm_write_seq`

## Requirements
- R1: The array holds 2048 bytes addressed by `addr[10:0]`. Once a write has completed, a read of that address returns the written byte.
- R2: `dout_en` is high exactly when `ce_n` and `oe_n` are both low. Whenever `dout_en` is low, `dout` is 8'h00.
- R3: A write begins in the first cycle in which `ce_n` and `we_n` are both low, provided `oe_n` is high and `oe_hv` is low. The address sampled in that cycle is the target. Later changes of `addr` during the strobe are ignored.
- R4: The data byte is sampled in the first cycle in which either `ce_n` or `we_n` is high again. Later changes of `din` are ignored.
- R5: `busy` rises in the cycle after the data byte is sampled and stays high for exactly WRITE_CYCLES clock cycles.
- R6: While a byte write is busy, a read of the target address returns the inverse of bit 7 of the data being written on bit 7, with bits 6..0 zero. Reads of other addresses return their stored data.
- R7: If `oe_n` is low when the strobe starts, or goes low at any time before the data byte is sampled, the write is inhibited. `busy` stays low and the target byte keeps its old value.
- R8: Write strobes that begin while `busy` is high are ignored and change no byte.
- R9: Holding `ce_n` and `we_n` low with `oe_hv` high for CLEAR_HOLD consecutive cycles makes `busy` rise in the next cycle. `busy` then stays high for 2048 cycles, and afterwards every byte reads 8'hFF. Another wipe requires the strobe to be released first.
- R10: While a wipe is running, every read returns 8'h00, which is the status byte for erased data.
- R11: A write replaces the old byte completely: the byte is erased to 8'hFF before it is programmed. The result does not depend on the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low; must stay high during a write |
| we_n | input | 1 | Write strobe, active low |
| oe_hv | input | 1 | High-voltage level present on output enable (wipe qualifier) |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | Output drive enable |
| busy | output | 1 | Internal write or wipe cycle in progress |

## Verification
The bench moves the address in the middle of a strobe. A design that latched the address late would write the neighbouring byte. It also changes the data right after the strobe ends, which catches a design that samples the data too late. It drops output enable part-way through a strobe and starts a second strobe during a busy cycle; a design that failed to inhibit or to ignore these would corrupt a preset byte. It polls the target byte and an unrelated byte during busy, overwrites a byte with its complement, and times both the busy window and the delay from wipe request to busy. A wrong status encoding, a design that merges old and new data, or an off-by-one timer each shows up as a wrong byte or a wrong cycle count.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] ERASED = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_ERASE,
        ST_PROG,
        ST_WIPE
    } seq_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // status byte: top bit inverted, rest forced low
    function automatic logic [DATA_W-1:0] poll_byte(input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] s;
        s = '0;
        s[DATA_W-1] = ~d[DATA_W-1];
        return s;
    endfunction
endpackage

// File: rtl/nvm_strobe_qual.sv
module nvm_strobe_qual
    import nvm_pkg::*;
#(
    parameter int CLEAR_HOLD = 2_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic oe_hv,
    input  logic idle,
    output logic wstart,
    output logic wend,
    output logic clr_go
);
    localparam int HC_W = $clog2(CLEAR_HOLD + 1);

    logic            act;
    logic            act_q;
    logic            hv_act;
    logic [HC_W-1:0] hcnt;
    logic            clr_done;

    assign act    = ~ce_n & ~we_n;
    assign hv_act = act & oe_hv;

    // strobe overlap begins on the later falling edge, ends on the first rising
    assign wstart = act & ~act_q & oe_n & ~oe_hv;
    assign wend   = ~act & act_q;
    assign clr_go = hv_act & ~clr_done & idle & (hcnt == HC_W'(CLEAR_HOLD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= 1'b0;
            hcnt     <= '0;
            clr_done <= 1'b0;
        end else begin
            act_q <= act;
            if (!hv_act) begin
                hcnt     <= '0;
                clr_done <= 1'b0;
            end else if (!clr_done && idle) begin
                if (hcnt == HC_W'(CLEAR_HOLD - 1))
                    clr_done <= 1'b1;
                else
                    hcnt <= hcnt + 1'b1;
            end
        end
    end

    // R9: one wipe per held strobe
    a_r9_clear_one_shot: assert property (@(posedge clk) disable iff (rst)
        clr_go |=> !clr_go);
endmodule

// File: rtl/nvm_array.sv
module nvm_array
    import nvm_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int WRITE_CYCLES = 250_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              oe_n,
    input  logic              oe_hv,
    input  logic              wstart,
    input  logic              wend,
    input  logic              clr_go,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              idle,
    output logic              busy,
    output logic              wiping,
    output logic              writing,
    output wr_req_t           lat,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int CNT_W     = $clog2(WRITE_CYCLES + 1);
    localparam int ERASE_CYC = (WRITE_CYCLES / 2 < 1) ? 1 : WRITE_CYCLES / 2;

    seq_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] ptr;
    logic              last_prog;

    assign idle      = (state == ST_IDLE);
    assign writing   = (state == ST_ERASE) || (state == ST_PROG);
    assign wiping    = (state == ST_WIPE);
    assign busy      = writing || wiping;
    assign last_prog = (state == ST_PROG) && (cnt == CNT_W'(WRITE_CYCLES - 1));

    // single write port: erase byte, program byte, or wipe sweep
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = lat.addr;
        mem_wdata = ERASED;
        if (wiping) begin
            mem_we    = 1'b1;
            mem_waddr = ptr;
        end else if (state == ST_ERASE && cnt == '0) begin
            mem_we    = 1'b1;
        end else if (last_prog) begin
            mem_we    = 1'b1;
            mem_wdata = lat.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ptr   <= '0;
            lat   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (clr_go) begin
                        state <= ST_WIPE;
                        ptr   <= '0;
                    end else if (wstart) begin
                        state    <= ST_ARMED;
                        lat.addr <= addr;
                    end
                end
                ST_ARMED: begin
                    if (!oe_n || oe_hv) begin
                        state <= ST_IDLE;
                    end else if (wend) begin
                        state    <= ST_ERASE;
                        lat.data <= din;
                        cnt      <= '0;
                    end
                end
                ST_ERASE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(ERASE_CYC - 1))
                        state <= ST_PROG;
                end
                ST_PROG: begin
                    cnt <= cnt + 1'b1;
                    if (last_prog)
                        state <= ST_IDLE;
                end
                ST_WIPE: begin
                    ptr <= ptr + 1'b1;
                    if (ptr == ADDR_W'(DEPTH - 1))
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: a qualified strobe end launches the timed cycle
    a_r5_busy_after_end: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && wend && oe_n && !oe_hv) |=> busy);
    // R7: output enable low while armed discards the write
    a_r7_inhibit: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && !oe_n) |=> !busy);
    // R8: latched request frozen while busy
    a_r8_latch_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(lat.addr) && $stable(lat.data)));
    // R9: wipe request enters the sweep
    a_r9_clear_enters: assert property (@(posedge clk) disable iff (rst)
        clr_go |=> (state == ST_WIPE));
    // R9: sweep ends after the last byte
    a_r9_wipe_exit: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WIPE && ptr == ADDR_W'(DEPTH - 1)) |=> (state == ST_IDLE));
endmodule

// File: rtl/nvm_write_seq.sv
module nvm_write_seq
    import nvm_pkg::*;
#(
    parameter int WRITE_CYCLES = 250_000,
    parameter int CLEAR_HOLD   = 2_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy
);
    logic              wstart, wend, clr_go, idle;
    logic              wiping, writing;
    wr_req_t           lat;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] rd_sel;

    nvm_strobe_qual #(.CLEAR_HOLD(CLEAR_HOLD)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .oe_hv  (oe_hv),
        .idle   (idle),
        .wstart (wstart),
        .wend   (wend),
        .clr_go (clr_go)
    );

    nvm_seq #(.WRITE_CYCLES(WRITE_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .oe_n      (oe_n),
        .oe_hv     (oe_hv),
        .wstart    (wstart),
        .wend      (wend),
        .clr_go    (clr_go),
        .addr      (addr),
        .din       (din),
        .idle      (idle),
        .busy      (busy),
        .wiping    (wiping),
        .writing   (writing),
        .lat       (lat),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata)
    );

    nvm_array u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (addr),
        .rdata (rdata)
    );

    always_comb begin
        if (wiping)
            rd_sel = poll_byte(ERASED);
        else if (writing && addr == lat.addr)
            rd_sel = poll_byte(lat.data);
        else
            rd_sel = rdata;
    end

    assign dout_en = ~ce_n & ~oe_n;
    assign dout    = dout_en ? rd_sel : '0;

    // R2: no drive while deselected
    a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == '0));
    // R10: wipe reads show the erased-status byte
    a_r10_wipe_status: assert property (@(posedge clk) disable iff (rst)
        (wiping && dout_en) |-> (dout == poll_byte(ERASED)));
endmodule

// File: tb/nvm_write_seq_test.sv
module nvm_write_seq_test;
    localparam int W = 40;
    localparam int H = 20;
    localparam int NV = 6;
    localparam logic [18:0] VECS [NV] = '{
        {11'h000, 8'h5A}, {11'h7FF, 8'hA5}, {11'h155, 8'h00},
        {11'h2AA, 8'hFF}, {11'h400, 8'h81}, {11'h0F0, 8'h7E}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, oe_hv = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_en, busy;

    int checks = 0;
    int errors = 0;

    nvm_write_seq #(.WRITE_CYCLES(W), .CLEAR_HOLD(H)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .oe_hv(oe_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // read at the current time (between edges), leaves bus selected for read
    task automatic rd(input logic [10:0] a, output logic [7:0] v);
        we_n = 1'b1; oe_hv = 1'b0; ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #1 v = dout;
    endtask

    task automatic deselect();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; oe_hv = 1'b0;
    endtask

    // ends at the negedge right after the edge that samples the data
    task automatic wr(input logic [10:0] a, input logic [7:0] d,
                      input logic [10:0] a_late, input logic [7:0] d_late,
                      input logic oe_start, input logic oe_drop);
        @(negedge clk);
        addr = a; din = d; oe_hv = 1'b0; oe_n = oe_start; we_n = 1'b0; ce_n = 1'b0;
        @(negedge clk);
        addr = a_late;
        if (oe_drop) oe_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; din = d_late;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wr_done(input logic [10:0] a, input logic [7:0] d);
        int n;
        wr(a, d, a, ~d, 1'b1, 1'b0);
        count_busy(n);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n, n_rise;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R5 reset busy low", int'(busy), 0);
        chk("R2 reset no drive", int'(dout_en), 0);

        // R2 output gating
        ce_n = 1'b0; oe_n = 1'b1; #1;
        chk("R2 oe high no drive", int'(dout_en), 0);
        chk("R2 dout zero", int'(dout), 0);
        ce_n = 1'b1; oe_n = 1'b0; #1;
        chk("R2 ce high no drive", int'(dout_en), 0);
        ce_n = 1'b0; #1;
        chk("R2 both low drive", int'(dout_en), 1);
        deselect();

        // R9/R10 chip wipe
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; oe_hv = 1'b1;
        n_rise = 0;
        while (!busy && n_rise < 1000) begin
            n_rise++;
            @(negedge clk);
        end
        chk("R9 wipe request delay", n_rise, H);
        n = 0;
        while (busy && n < 10000) begin
            if (n == 2) begin
                rd(11'h123, v);
                chk("R10 status during wipe", int'(v), 8'h00);
            end
            n++;
            @(negedge clk);
        end
        deselect();
        chk("R9 wipe busy length", n, 2048);
        rd(11'h000, v); chk("R9 erased low end", int'(v), 8'hFF);
        rd(11'h7FF, v); chk("R9 erased high end", int'(v), 8'hFF);
        rd(11'h3C3, v); chk("R9 erased middle", int'(v), 8'hFF);
        deselect();

        // vector table: R1 readback, R4 late data ignored, R5 busy length
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i][18:8], VECS[i][7:0], VECS[i][18:8], ~VECS[i][7:0], 1'b1, 1'b0);
            count_busy(n);
            chk("R5 busy length", n, W);
            rd(VECS[i][18:8], v);
            chk("R1 R4 readback", int'(v), int'(VECS[i][7:0]));
            deselect();
        end

        // R6 polling: target shows status, others true data
        wr(11'h3A5, 8'h11, 11'h3A5, 8'h00, 1'b1, 1'b0);
        rd(11'h3A5, v); chk("R6 poll bit7 of 0x11", int'(v), 8'h80);
        rd(11'h000, v); chk("R6 other address", int'(v), 8'h5A);
        count_busy(n);
        rd(11'h3A5, v); chk("R6 true data after", int'(v), 8'h11);
        deselect();
        wr(11'h3A5, 8'hEE, 11'h3A5, 8'h00, 1'b1, 1'b0);
        rd(11'h3A5, v); chk("R6 poll bit7 of 0xEE", int'(v), 8'h00);
        count_busy(n);
        // R11 full replacement, not merged with 0x11
        rd(11'h3A5, v); chk("R11 overwrite", int'(v), 8'hEE);
        deselect();

        // R3 address taken at strobe start
        wr_done(11'h101, 8'h22);
        wr(11'h100, 8'h77, 11'h101, 8'h00, 1'b1, 1'b0);
        count_busy(n);
        rd(11'h100, v); chk("R3 early address", int'(v), 8'h77);
        rd(11'h101, v); chk("R3 late address untouched", int'(v), 8'h22);
        deselect();

        // R7 inhibit: oe dropped mid-strobe, and oe low at start
        wr_done(11'h200, 8'h44);
        wr(11'h200, 8'h99, 11'h200, 8'h99, 1'b1, 1'b1);
        chk("R7 no busy on drop", int'(busy), 0);
        rd(11'h200, v); chk("R7 byte kept on drop", int'(v), 8'h44);
        deselect();
        wr(11'h200, 8'h66, 11'h200, 8'h66, 1'b0, 1'b0);
        chk("R7 no busy oe low start", int'(busy), 0);
        rd(11'h200, v); chk("R7 byte kept oe low", int'(v), 8'h44);
        deselect();

        // R8 strobe during busy ignored
        wr_done(11'h301, 8'h56);
        wr(11'h300, 8'h12, 11'h300, 8'h00, 1'b1, 1'b0);
        wr(11'h301, 8'h34, 11'h301, 8'h34, 1'b1, 1'b0);
        count_busy(n);
        repeat (3) @(negedge clk);
        chk("R8 no second cycle", int'(busy), 0);
        rd(11'h300, v); chk("R8 first write done", int'(v), 8'h12);
        rd(11'h301, v); chk("R8 busy strobe ignored", int'(v), 8'h56);
        deselect();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule